// File: doc/BRIEF.md
# Chained Serial Command Receiver

This block is the receive front end for a serial command port. It takes 16-bit command words over three wires: an active-low select, a serial clock and a serial data line. It also drives a serial data output, so that several devices can share one select and one clock while their data lines are chained in series. The three serial pins are sampled in a faster system clock. Each pin passes through a synchroniser, and the block detects edges on the synchronised signals. There is no separate clock domain for the serial clock.

While the select line is low, each rising edge of the serial clock shifts one data bit into a 16-bit shift register, most significant bit first. In each word, four control bits come first and twelve data bits follow. The block does not decode them. When the select line rises, the current contents of the shift register are copied into a parallel word register, and a strobe lasting one system clock tells the downstream decoder that a new word is ready. The transfer is set off by the select edge and not by counting bits, so a frame of any length leaves the last 16 bits received in the word register.

The data output follows the bit that leaves the top of the shift register. It changes on the falling edge of the serial clock, so a word appears on it 16 serial clocks after it was shifted in. A low level on the active-low clear input empties the shift register, the word register and the data output immediately, without waiting for the system clock.

Top module: `spi_chain_rx`

## Requirements
- R1: After the synchronous reset, word_q reads 0, word_vld is low and sdo is low.
- R2: While cs_n_pin is low, each rising edge of sck_pin shifts sdi_pin into bit 0 of the shift register, and the older bits move toward bit 15. A frame of exactly 16 bits therefore leaves the first bit sent in word_q[15] and the last bit sent in word_q[0].
- R3: While cs_n_pin is high, edges on sck_pin and changes on sdi_pin leave the shift register unchanged. A later frame with no clock edges captures the earlier contents.
- R4: Each rising edge of cs_n_pin raises word_vld for exactly one system clock. word_vld stays low at all other times.
- R5: A frame with fewer or more than 16 clock edges still transfers on the cs_n_pin rising edge, and word_q holds the last 16 bits received, including bits left over from earlier frames.
- R6: Just before each rising edge of sck_pin, sdo equals the current bit 15 of the shift register. sdo changes only on falling edges of sck_pin taken while cs_n_pin is low, so a word shifted in comes out MSB first during the next 16 clocks.
- R7: A low level on clr_n clears the shift register, word_q and sdo to 0 at once, without a system clock edge.
- R8: word_q changes only in the system clock cycle in which word_vld rises, apart from reset and clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear of the shift register, word register and sdo |
| cs_n_pin | input | 1 | Active-low select from the serial bus |
| sck_pin | input | 1 | Serial clock from the bus |
| sdi_pin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out to the next device in the chain |
| word_q | output | WORD_W | Last word transferred on a select rising edge |
| word_vld | output | 1 | One-cycle strobe marking a new word_q |

## Verification
The hardest case to reach is the chain output between frames. The value on sdo must come from a word shifted in during an earlier frame, and neither the idle gap nor clock pulses sent while the device is not selected may disturb it. To get there, the bench sends words back to back. Before each rising clock edge it checks sdo against a reference shift register. It also places frames with no clock edges, short frames and long frames, and deselected clock bursts between full frames, so that the leftover bits must show up both on word_q and on sdo.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef struct packed {
    logic cs_high;
    logic cs_rise;
    logic sck_rise;
    logic sck_fall;
    logic sdi;
  } pin_evt_t;
endpackage

// File: rtl/scr_sync_bit.sv
module scr_sync_bit #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scr_pin_front.sv
module scr_pin_front
  import scr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cs_n_pin,
  input  logic     sck_pin,
  input  logic     sdi_pin,
  output pin_evt_t evt
);
  localparam int              NPIN = 3;
  localparam logic [NPIN-1:0] IDLE = 3'b001;  // select idles high

  logic [NPIN-1:0] raw;
  logic [NPIN-1:0] syn;
  logic            cs_d, sck_d;

  assign raw = {sdi_pin, sck_pin, cs_n_pin};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    scr_sync_bit #(.STAGES(STAGES), .RST_VAL(IDLE[g])) u_sync (
      .clk(clk), .rst(rst), .d(raw[g]), .q(syn[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= syn[0];
      sck_d <= syn[1];
    end
  end

  always_comb begin
    evt.cs_high  = syn[0];
    evt.cs_rise  = syn[0] & ~cs_d;
    evt.sck_rise = syn[1] & ~sck_d & ~syn[0];
    evt.sck_fall = ~syn[1] & sck_d & ~syn[0];
    evt.sdi      = syn[2];
  end
endmodule

// File: rtl/scr_shift.sv
module scr_shift
  import scr_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  pin_evt_t          evt,
  output logic [WORD_W-1:0] sr,
  output logic              sdo
);
  localparam int TOP = WORD_W - 1;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sr  <= '0;
      sdo <= 1'b0;
    end else if (rst) begin
      sr  <= '0;
      sdo <= 1'b0;
    end else begin
      if (evt.sck_rise) sr  <= {sr[TOP-1:0], evt.sdi};
      if (evt.sck_fall) sdo <= sr[TOP];
    end
  end

  AST_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (rst || !clr_n)
    evt.cs_high |=> $stable(sr)); // R3
  AST_SDO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (rst || !clr_n)
    evt.cs_high |=> $stable(sdo)); // R6
endmodule

// File: rtl/scr_capture.sv
module scr_capture
  import scr_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  pin_evt_t          evt,
  input  logic [WORD_W-1:0] sr,
  output logic [WORD_W-1:0] word_q,
  output logic              word_vld
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      word_q   <= '0;
      word_vld <= 1'b0;
    end else if (rst) begin
      word_q   <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= evt.cs_rise;
      if (evt.cs_rise) word_q <= sr;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst || !clr_n)
    word_vld |=> !word_vld); // R4
  AST_STROBE_DESELECTED: assert property (@(posedge clk) disable iff (rst || !clr_n)
    word_vld |-> evt.cs_high); // R4
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !word_vld |-> $stable(word_q)); // R8
endmodule

// File: rtl/spi_chain_rx.sv
module spi_chain_rx
  import scr_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              cs_n_pin,
  input  logic              sck_pin,
  input  logic              sdi_pin,
  output logic              sdo,
  output logic [WORD_W-1:0] word_q,
  output logic              word_vld
);
  pin_evt_t          evt;
  logic [WORD_W-1:0] sr;

  scr_pin_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
    .sdi_pin(sdi_pin), .evt(evt)
  );

  scr_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .clr_n(clr_n), .evt(evt), .sr(sr), .sdo(sdo)
  );

  scr_capture #(.WORD_W(WORD_W)) u_capture (
    .clk(clk), .rst(rst), .clr_n(clr_n), .evt(evt), .sr(sr),
    .word_q(word_q), .word_vld(word_vld)
  );

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (word_q == '0 && !sdo && !word_vld)); // R7
endmodule

// File: tb/spi_chain_rx_test.sv
module spi_chain_rx_test;
  localparam int W = 16;
  localparam int H = 6;  // system clocks per serial half period

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr_n = 1'b1;
  logic         cs_n_pin = 1'b1;
  logic         sck_pin = 1'b0;
  logic         sdi_pin = 1'b0;
  logic         sdo;
  logic [W-1:0] word_q;
  logic         word_vld;

  int checks = 0;
  int errors = 0;
  int vld_hi = 0;
  int vld_edges = 0;
  logic vld_prev = 1'b0;
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;

  spi_chain_rx #(.WORD_W(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n_pin(cs_n_pin),
    .sck_pin(sck_pin), .sdi_pin(sdi_pin), .sdo(sdo),
    .word_q(word_q), .word_vld(word_vld)
  );

  always @(posedge clk) begin
    if (word_vld) vld_hi++;
    if (word_vld && !vld_prev) vld_edges++;
    vld_prev <= word_vld;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Shift n bits of v (MSB of the n first); check sdo before each rise (R6)
  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi_pin = v[i];
      wait_clk(H);
      chk("R6", sdo, model[W-1]);
      sck_pin = 1'b1;
      model = {model[W-2:0], v[i]};
      wait_clk(H);
      sck_pin = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n, input string req);
    int h0, e0;
    h0 = vld_hi; e0 = vld_edges;
    cs_n_pin = 1'b0;
    wait_clk(H);
    send_bits(v, n);
    wait_clk(H);
    cs_n_pin = 1'b1;
    wait_clk(8);
    chk(req, word_q, model);
    chk("R4", vld_hi - h0, 1);
    chk("R4", vld_edges - e0, 1);
  endtask

  initial begin
    wait_clk(200000 - 10);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);
    chk("R1", word_q, 0);
    chk("R1", word_vld, 0);
    chk("R1", sdo, 0);

    // R2: walking ones and zeros, MSB first
    for (int k = 0; k < W; k++) begin
      frame(32'(16'h1 << k), W, "R2");
      frame(32'(~(16'h1 << k)), W, "R2");
    end
    // R2/R6: arithmetic patterns back to back
    for (int i = 0; i < 16; i++)
      frame(32'(16'((i * 16'h1357) ^ 16'hA5C3)), W, "R2");

    // R3: deselected clock bursts leave the register alone
    frame(32'h0000_C3A5, W, "R2");
    for (int i = 0; i < 10; i++) begin
      sdi_pin = i[0];
      wait_clk(H);
      sck_pin = 1'b1;
      wait_clk(H);
      sck_pin = 1'b0;
    end
    chk("R3", word_q, 16'hC3A5);
    chk("R6", sdo, model[W-1]);
    frame(0, 0, "R3");
    chk("R3", word_q, 16'hC3A5);

    // R5: short and long frames
    frame(32'h0000_0009, 4, "R5");
    chk("R5", word_q, 16'h3A59);
    frame(32'h000A_BCDE, 20, "R5");
    chk("R5", word_q, 16'hBCDE);
    frame(32'h0000_007F, 7, "R5");

    // R7: asynchronous clear between clock edges
    frame(32'h0000_FFFF, W, "R2");
    @(posedge clk);
    #2;
    clr_n = 1'b0;
    #1;
    chk("R7", word_q, 0);
    chk("R7", sdo, 0);
    wait_clk(4);
    clr_n = 1'b1;
    model = '0;
    wait_clk(3);
    frame(0, 0, "R7");
    frame(32'h0000_8001, W, "R2");
    frame(32'h0000_1234, W, "R6");

    // R8: word_q holds with no select activity
    wait_clk(40);
    chk("R8", word_q, 16'h1234);
    chk("R4", word_vld, 0);

    finish_run();
  end
endmodule